// File: doc/BRIEF.md
# UART Modem Control and Local Loopback

This block sits beside one UART channel and owns its modem-control register. Software writes an 8-bit control word over a small register bus. That word drives the three active-low modem output pins (request-to-send, data-terminal-ready and a general output). It chooses whether the baud generator sees every input clock or every fourth one. It also decides whether serial data goes straight to the pins or through an external infrared pulse encoder and decoder, which connect here only as ports.

A diagnostic loopback mode cuts the channel off from its pins. Transmit data is turned back into receive data inside the block. The transmit pin rests at its idle level, and the modem outputs go inactive. The modem status inputs are then taken from the low four control bits instead of the synchronized pins. The block keeps the modem status register, including its four change bits, and raises a change interrupt when the interrupt-enable input allows it.

Register map: address 0 is the control word; address 1 is the status register, which is read-only and clears its change bits when read. Any other address reads as zero. Read data is combinational from the address.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the control word reads 0x00, the RTS, DTR and OP2 pins are high, the clock enable is high on every cycle, and the interrupt is low.
- R2: Outside loopback, control bit 1 set drives the RTS pin low, bit 0 set drives the DTR pin low, and bit 3 set drives the OP2 pin low; a clear bit drives its pin high.
- R3: Control bit 5 always reads 0, whatever is written to it; the other seven bits read back as written.
- R4: With control bit 7 clear the clock enable is high on every cycle; with it set the enable is high on exactly one cycle in every PRESCALE_DIV (default 4).
- R5: With control bit 6 set and loopback off, the TX pin follows the encoder output, the encoder input follows the transmit data, the decoder input follows the RX pin, and the receive data follows the decoder output.
- R6: With control bit 6 and bit 4 clear, the TX pin follows the transmit data and the receive data follows the RX pin; the encoder input rests at 1 and the decoder input at 0.
- R7: With control bit 4 set, receive data equals transmit data. The TX pin rests at 1 (bit 6 clear) or at 0 (bit 6 set). The RTS, DTR and OP2 pins are high, the encoder input rests at 1, and the decoder input rests at 0.
- R8: In loopback, status bit 4 (CTS) equals control bit 1, bit 5 (DSR) equals bit 0, bit 6 (RI) equals bit 2, and bit 7 (CD) equals bit 3; the modem input pins have no effect.
- R9: Outside loopback, status bits 7..4 are the inverted CD, RI, DSR and CTS pins, seen through a SYNC_STAGES-flop synchronizer.
- R10: Status bit 0 latches on any change of CTS, bit 1 on any change of DSR, bit 3 on any change of CD, and bit 2 when RI goes from 1 to 0; all four clear on a status read, and a change in the cycle of the read still latches.
- R11: The interrupt is high exactly when the enable input is high and any of status bits 3..0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en_i | input | 1 | Register write strobe |
| reg_rd_en_i | input | 1 | Register read strobe (clears change bits at address 1) |
| reg_addr_i | input | ADDR_W | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data |
| msr_irq_en_i | input | 1 | Modem-status interrupt enable |
| irq_o | output | 1 | Modem-status change interrupt |
| clk_en_o | output | 1 | Prescaled clock enable to the baud generator |
| core_txd_i | input | 1 | Transmit data from the shifter |
| core_rxd_o | output | 1 | Receive data to the shifter |
| enc_in_o | output | 1 | Data to the infrared encoder |
| enc_out_i | input | 1 | Pulses from the infrared encoder |
| dec_in_o | output | 1 | Pin data to the infrared decoder |
| dec_out_i | input | 1 | Data from the infrared decoder |
| pad_tx_o | output | 1 | TX pin |
| pad_rx_i | input | 1 | RX pin |
| pad_cts_n_i | input | 1 | CTS pin, active low |
| pad_dsr_n_i | input | 1 | DSR pin, active low |
| pad_cd_n_i | input | 1 | CD pin, active low |
| pad_ri_n_i | input | 1 | RI pin, active low |
| pad_rts_n_o | output | 1 | RTS pin, active low |
| pad_dtr_n_o | output | 1 | DTR pin, active low |
| pad_op2_n_o | output | 1 | General output pin, active low |

## Verification
The hardest case to reach is the set of change bits produced by a mode switch. Entering or leaving loopback swaps the status source in a single cycle, so several change bits can latch at once, while the RI edge bit must stay clear on a rising RI. The bench sets the control bits in loopback to create each edge directly. It holds the modem pins active while in loopback to show that they are ignored. It returns the pins to idle before leaving loopback, so that the deltas caused by the exit are known in advance, and then reads them back.

// File: rtl/umc_pkg.sv
package umc_pkg;
   localparam int REG_W   = 8;
   localparam int CB_DTR  = 0;
   localparam int CB_RTS  = 1;
   localparam int CB_OP1  = 2;
   localparam int CB_OP2  = 3;
   localparam int CB_LOOP = 4;
   localparam int CB_RSVD = 5;
   localparam int CB_IRDA = 6;
   localparam int CB_DIV  = 7;
   localparam int RA_CTRL = 0;
   localparam int RA_STAT = 1;

   // ordered so the packed struct lands directly on status bits 7..4 / 3..0
   typedef struct packed {
      logic cd;
      logic ri;
      logic dsr;
      logic cts;
   } mstat_t;
endpackage

// File: rtl/umc_ctrl_reg.sv
module umc_ctrl_reg
   import umc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] ctrl_o
);
   localparam logic [REG_W-1:0] KEEP_MASK = ~(REG_W'(1) << CB_RSVD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ctrl_o <= '0;
      else if (wr_en) ctrl_o <= wdata & KEEP_MASK;
   end
endmodule

// File: rtl/umc_prescale.sv
module umc_prescale #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic div_sel,
   output logic tick_o
);
   localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (cnt_q == LAST) cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
   end

   assign tick_o = div_sel ? (cnt_q == LAST) : 1'b1;
endmodule

// File: rtl/umc_route.sv
module umc_route (
   input  logic loop,
   input  logic irda,
   input  logic rts_bit,
   input  logic dtr_bit,
   input  logic op2_bit,
   input  logic core_txd,
   input  logic pad_rx,
   input  logic enc_out,
   input  logic dec_out,
   output logic pad_tx,
   output logic core_rxd,
   output logic enc_in,
   output logic dec_in,
   output logic rts_n,
   output logic dtr_n,
   output logic op2_n
);
   logic ir_live;

   assign ir_live = irda && !loop;

   always_comb begin
      if (loop) begin
         pad_tx   = !irda;
         core_rxd = core_txd;
      end else if (irda) begin
         pad_tx   = enc_out;
         core_rxd = dec_out;
      end else begin
         pad_tx   = core_txd;
         core_rxd = pad_rx;
      end
   end

   assign enc_in = ir_live ? core_txd : 1'b1;
   assign dec_in = ir_live ? pad_rx   : 1'b0;
   assign rts_n  = loop | !rts_bit;
   assign dtr_n  = loop | !dtr_bit;
   assign op2_n  = loop | !op2_bit;
endmodule

// File: rtl/umc_status.sv
module umc_status
   import umc_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   loop,
   input  mstat_t loop_src,
   input  mstat_t pin_act,
   input  logic   clr,
   output mstat_t stat_o,
   output mstat_t delta_o
);
   mstat_t sync_q [SYNC_STAGES];
   mstat_t prev_q;
   mstat_t chg;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[0] <= '0;
            else        sync_q[0] <= pin_act;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[g] <= '0;
            else        sync_q[g] <= sync_q[g-1];
         end
      end
   end

   assign stat_o = loop ? loop_src : sync_q[SYNC_STAGES-1];

   always_comb begin
      chg.cts = stat_o.cts ^ prev_q.cts;
      chg.dsr = stat_o.dsr ^ prev_q.dsr;
      chg.cd  = stat_o.cd  ^ prev_q.cd;
      chg.ri  = prev_q.ri & !stat_o.ri;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         delta_o <= '0;
      end else begin
         prev_q  <= stat_o;
         delta_o <= (clr ? mstat_t'('0) : delta_o) | chg;
      end
   end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
   import umc_pkg::*;
#(
   parameter int ADDR_W       = 2,
   parameter int PRESCALE_DIV = 4,
   parameter int SYNC_STAGES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en_i,
   input  logic              reg_rd_en_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [REG_W-1:0]  reg_wdata_i,
   output logic [REG_W-1:0]  reg_rdata_o,
   input  logic              msr_irq_en_i,
   output logic              irq_o,
   output logic              clk_en_o,
   input  logic              core_txd_i,
   output logic              core_rxd_o,
   output logic              enc_in_o,
   input  logic              enc_out_i,
   output logic              dec_in_o,
   input  logic              dec_out_i,
   output logic              pad_tx_o,
   input  logic              pad_rx_i,
   input  logic              pad_cts_n_i,
   input  logic              pad_dsr_n_i,
   input  logic              pad_cd_n_i,
   input  logic              pad_ri_n_i,
   output logic              pad_rts_n_o,
   output logic              pad_dtr_n_o,
   output logic              pad_op2_n_o
);
   if (ADDR_W < 1)        begin : g_bad_addr  $error("ADDR_W must be at least 1");        end
   if (PRESCALE_DIV < 2)  begin : g_bad_div   $error("PRESCALE_DIV must be at least 2");  end
   if (SYNC_STAGES < 1)   begin : g_bad_sync  $error("SYNC_STAGES must be at least 1");   end

   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(RA_CTRL);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(RA_STAT);

   logic [REG_W-1:0] ctrl;
   logic             wr_ctrl, rd_stat;
   mstat_t           stat, delta, loop_src, pin_act;

   assign wr_ctrl = reg_wr_en_i && (reg_addr_i == A_CTRL);
   assign rd_stat = reg_rd_en_i && (reg_addr_i == A_STAT);

   umc_ctrl_reg u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_ctrl),
      .wdata  (reg_wdata_i),
      .ctrl_o (ctrl)
   );

   umc_prescale #(.DIV(PRESCALE_DIV)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .div_sel (ctrl[CB_DIV]),
      .tick_o  (clk_en_o)
   );

   umc_route u_route (
      .loop     (ctrl[CB_LOOP]),
      .irda     (ctrl[CB_IRDA]),
      .rts_bit  (ctrl[CB_RTS]),
      .dtr_bit  (ctrl[CB_DTR]),
      .op2_bit  (ctrl[CB_OP2]),
      .core_txd (core_txd_i),
      .pad_rx   (pad_rx_i),
      .enc_out  (enc_out_i),
      .dec_out  (dec_out_i),
      .pad_tx   (pad_tx_o),
      .core_rxd (core_rxd_o),
      .enc_in   (enc_in_o),
      .dec_in   (dec_in_o),
      .rts_n    (pad_rts_n_o),
      .dtr_n    (pad_dtr_n_o),
      .op2_n    (pad_op2_n_o)
   );

   always_comb begin
      loop_src.cts = ctrl[CB_RTS];
      loop_src.dsr = ctrl[CB_DTR];
      loop_src.ri  = ctrl[CB_OP1];
      loop_src.cd  = ctrl[CB_OP2];
      pin_act.cts  = !pad_cts_n_i;
      pin_act.dsr  = !pad_dsr_n_i;
      pin_act.ri   = !pad_ri_n_i;
      pin_act.cd   = !pad_cd_n_i;
   end

   umc_status #(.SYNC_STAGES(SYNC_STAGES)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .loop     (ctrl[CB_LOOP]),
      .loop_src (loop_src),
      .pin_act  (pin_act),
      .clr      (rd_stat),
      .stat_o   (stat),
      .delta_o  (delta)
   );

   always_comb begin
      if (reg_addr_i == A_CTRL)      reg_rdata_o = ctrl;
      else if (reg_addr_i == A_STAT) reg_rdata_o = {stat, delta};
      else                           reg_rdata_o = '0;
   end

   assign irq_o = msr_irq_en_i && (delta != '0);
endmodule

// File: rtl/umc_checker.sv
module umc_checker
   import umc_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] ctrl,
   input mstat_t           stat,
   input mstat_t           delta,
   input logic             msr_irq_en_i,
   input logic             irq_o,
   input logic             clk_en_o,
   input logic             pad_tx_o,
   input logic             pad_rts_n_o,
   input logic             core_txd_i,
   input logic             core_rxd_o
);
   // R3: reserved bit never stored
   p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[CB_RSVD] == 1'b0);

   // R4: divided enable never high on two cycles in a row
   p_div_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[CB_DIV] && $past(ctrl[CB_DIV]) && clk_en_o) |=> !clk_en_o || !ctrl[CB_DIV] || !$past(ctrl[CB_DIV], 1));

   // R4: undivided enable stays high
   p_nodiv_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[CB_DIV] |-> clk_en_o);

   // R7: loopback parks TX at idle and releases RTS
   p_loop_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[CB_LOOP] |-> (pad_tx_o == !ctrl[CB_IRDA]) && pad_rts_n_o && (core_rxd_o == core_txd_i));

   // R8: loopback status follows control bits
   p_loop_stat_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[CB_LOOP] |-> (stat.cts == ctrl[CB_RTS]) && (stat.cd == ctrl[CB_OP2]));

   // R10: a CTS change always latches its delta
   p_dcts_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(stat.cts) |=> delta.cts);

   // R10: RI rising never latches the edge bit by itself
   p_teri_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(stat.ri) && !delta.ri) |=> !delta.ri);

   // R11: interrupt needs its enable
   p_irq_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> msr_irq_en_i);
endmodule

bind uart_modem_ctl umc_checker u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctrl         (ctrl),
   .stat         (stat),
   .delta        (delta),
   .msr_irq_en_i (msr_irq_en_i),
   .irq_o        (irq_o),
   .clk_en_o     (clk_en_o),
   .pad_tx_o     (pad_tx_o),
   .pad_rts_n_o  (pad_rts_n_o),
   .core_txd_i   (core_txd_i),
   .core_rxd_o   (core_rxd_o)
);

// File: tb/uart_modem_ctl_bench.sv
module uart_modem_ctl_bench;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 0, rd_en = 0, irq_en = 0;
   logic [AW-1:0] addr = '0;
   logic [7:0] wdata = '0, rdata;
   logic irq, clk_en, txd = 1, rxd, enc_in, enc_out = 0, dec_in, dec_out = 0;
   logic pad_tx, pad_rx = 1, cts_n = 1, dsr_n = 1, cd_n = 1, ri_n = 1;
   logic rts_n, dtr_n, op2_n;
   int checks = 0, errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   uart_modem_ctl #(.ADDR_W(AW)) u_uart_modem_ctl (
      .clk(clk), .rst_n(rst_n), .reg_wr_en_i(wr_en), .reg_rd_en_i(rd_en),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
      .msr_irq_en_i(irq_en), .irq_o(irq), .clk_en_o(clk_en),
      .core_txd_i(txd), .core_rxd_o(rxd), .enc_in_o(enc_in), .enc_out_i(enc_out),
      .dec_in_o(dec_in), .dec_out_i(dec_out), .pad_tx_o(pad_tx), .pad_rx_i(pad_rx),
      .pad_cts_n_i(cts_n), .pad_dsr_n_i(dsr_n), .pad_cd_n_i(cd_n), .pad_ri_n_i(ri_n),
      .pad_rts_n_o(rts_n), .pad_dtr_n_o(dtr_n), .pad_op2_n_o(op2_n)
   );

   task automatic chk(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(logic [7:0] d);
      @(negedge clk); wr_en = 1; addr = 0; wdata = d;
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd(int a, output logic [7:0] d);
      @(negedge clk); rd_en = 1; addr = AW'(a);
      #1 d = rdata;
      @(negedge clk); rd_en = 0;
   endtask

   task automatic settle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      logic [7:0] d;
      rd(0, d);
      chk("R1 ctrl", d, 8'h00);
      chk("R1 pins", {rts_n, dtr_n, op2_n}, 3'b111);
      chk("R1 clk_en", clk_en, 1);
      chk("R1 irq", irq, 0);
   endtask

   task automatic t_pins;
      wr(8'h02); #1 chk("R2 rts", {rts_n, dtr_n, op2_n}, 3'b011);
      wr(8'h01); #1 chk("R2 dtr", {rts_n, dtr_n, op2_n}, 3'b101);
      wr(8'h08); #1 chk("R2 op2", {rts_n, dtr_n, op2_n}, 3'b110);
   endtask

   task automatic t_reserved;
      logic [7:0] d;
      wr(8'h23); rd(0, d); chk("R3 rsvd", d, 8'h03);
      wr(8'hEF); rd(0, d); chk("R3 others", d, 8'hCF);
      wr(8'h00);
   endtask

   task automatic t_prescale;
      int n;
      wr(8'h80); n = 0;
      for (int i = 0; i < 16; i++) begin @(negedge clk); n += int'(clk_en); end
      chk("R4 div4", n, 4);
      wr(8'h00); n = 0;
      for (int i = 0; i < 16; i++) begin @(negedge clk); n += int'(clk_en); end
      chk("R4 div1", n, 16);
   endtask

   task automatic t_normal_route;
      wr(8'h00);
      txd = 0; pad_rx = 1; #1 chk("R6 route a", {pad_tx, rxd, enc_in, dec_in}, 4'b0110);
      txd = 1; pad_rx = 0; #1 chk("R6 route b", {pad_tx, rxd, enc_in, dec_in}, 4'b1010);
   endtask

   task automatic t_irda_route;
      wr(8'h40);
      txd = 0; pad_rx = 1; enc_out = 1; dec_out = 0;
      #1 chk("R5 route a", {pad_tx, rxd, enc_in, dec_in}, 4'b1001);
      txd = 1; pad_rx = 0; enc_out = 0; dec_out = 1;
      #1 chk("R5 route b", {pad_tx, rxd, enc_in, dec_in}, 4'b0110);
      pad_rx = 1; wr(8'h00);
   endtask

   task automatic t_loop_data;
      logic [7:0] d;
      wr(8'h1B); txd = 0; pad_rx = 1;
      #1 chk("R7 loop normal", {pad_tx, rxd, rts_n, dtr_n, op2_n, enc_in, dec_in}, 7'b1011110);
      wr(8'h5B); txd = 1; pad_rx = 0; enc_out = 1;
      #1 chk("R7 loop irda", {pad_tx, rxd, enc_in, dec_in}, 4'b0110);
      pad_rx = 1; enc_out = 0;
      wr(8'h00); settle(2); rd(1, d); rd(1, d);
   endtask

   task automatic t_loop_status;
      logic [7:0] d;
      wr(8'h1F);
      cts_n = 0; dsr_n = 0; cd_n = 0; ri_n = 0;
      rd(1, d); chk("R8 loop all on", d, 8'hFB);
      rd(1, d); chk("R10 cleared", d, 8'hF0);
      wr(8'h12); settle(3);
      rd(1, d); chk("R8 pins ignored / R10 ri fall", d, 8'h1E);
      cts_n = 1; dsr_n = 1; cd_n = 1; ri_n = 1;
      settle(4);
      wr(8'h00); settle(1);
      rd(1, d); chk("R10 loop exit", d, 8'h01);
   endtask

   task automatic t_pin_status;
      logic [7:0] d;
      @(negedge clk); cts_n = 0; settle(4);
      rd(1, d); chk("R9 cts / R10 dcts", d, 8'h11);
      @(negedge clk); ri_n = 0; settle(4);
      rd(1, d); chk("R9 ri rise no delta", d, 8'h50);
      @(negedge clk); ri_n = 1; dsr_n = 0; cd_n = 0; settle(4);
      rd(1, d); chk("R10 teri ddsr dcd", d, 8'hBE);
      @(negedge clk); cts_n = 1; dsr_n = 1; cd_n = 1; settle(4);
      rd(1, d); chk("R10 release", d, 8'h0B);
      rd(1, d); chk("R9 idle", d, 8'h00);
   endtask

   task automatic t_irq;
      logic [7:0] d;
      irq_en = 1; @(negedge clk); chk("R11 idle", irq, 0);
      dsr_n = 0; settle(4); chk("R11 raise", irq, 1);
      rd(1, d); #1 chk("R11 read clears", irq, 0);
      dsr_n = 1; settle(4); irq_en = 0; #1 chk("R11 masked", irq, 0);
      irq_en = 1; #1 chk("R11 unmasked", irq, 1);
      rd(1, d); irq_en = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_pins();
      t_reserved();
      t_prescale();
      t_normal_route();
      t_irda_route();
      t_loop_data();
      t_loop_status();
      t_pin_status();
      t_irq();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog got 0x0 expected 0x1");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule